// File: doc/BRIEF.md
# External Multiplexed Bus Cycle Controller

This block runs the external bus cycles of a 16-bit microcontroller core over a shared address/data bus. The core presents one request at a time: a byte address, write data, two byte enables, a read/write flag and a flag that marks an instruction fetch. The controller steps through an address phase, a data phase and an end phase. It drives the address, then either releases the bus for a read or drives the write data. It generates the read and write strobes, an address-latch strobe, a high-byte strobe and a fetch indicator.

Two configuration inputs set the shape of the strobes. The latch strobe runs either as a one-cycle positive pulse or as an active-low valid level that covers the whole cycle. In both shapes the address is captured on its falling edge. The high-byte strobe runs either as a byte-enable that covers the address and data phases or as a write strobe that covers only the data phase. The width of each cycle comes either from a static configuration bit or from a pin sampled in the data phase. When a cycle on the narrow bus has to carry a full word, the word is moved as two byte cycles and the core sees a single completion.

Top module: `xbus_cycle_ctl`

## Requirements
- R1: Out of reset and whenever no cycle is running, `busy` is 0, `rd_n`, `wr_n` and `hi_n` are 1, `ad_oe` is 0 and `fetch_o` is 0. `addr_strobe` is 0 in pulse mode and 1 in valid-level mode.
- R2: A request seen while idle starts the address phase on the next cycle, with `ad_out` showing the current byte address and `ad_oe` at 1. A data phase follows and then an end phase. `done` is high for exactly one cycle, in the end phase of the last byte cycle, and `rdata` is valid in that cycle.
- R3: With `cfg_adv_mode`=0, `addr_strobe` is high only during the address phase, which lasts one cycle.
- R4: With `cfg_adv_mode`=1, `addr_strobe` is low through the address and data phases and high in the end phase and in idle.
- R5: While `ready_in` is 0 in the data phase, the data phase repeats and all strobes hold their values.
- R6: On a read, `rd_n` is low only in the data phase, `ad_oe` is 0 there and `wr_n` stays 1.
- R7: On a write, `wr_n` is low only in the data phase, with `ad_oe`=1. `ad_out` carries the write word, except in a cycle that moves only the high byte: then that byte is driven on both byte lanes.
- R8: With `cfg_wrh_mode`=0, `hi_n` is low in the address phase of a write whose pending bytes include the high byte (enable bit 1). It is also low in the data phase when that cycle carries the high byte. It never goes low on a read.
- R9: With `cfg_wrh_mode`=1, `hi_n` is low only in the data phase of a write cycle that carries the high byte. It never goes low on a read.
- R10: With `cfg_dyn_width`=1, `bus_width_in` is sampled when the data phase completes: 0 gives a byte cycle and 1 gives a word cycle. A two-byte request (enables 11, even address) in a byte cycle becomes two cycles: the even address first with the low byte on AD[7:0], then the odd address with the high byte. For a read, each half is taken from AD[7:0] and the two halves form one word before `done`.
- R11: With `cfg_dyn_width`=0, `cfg_wide` sets the width (1 = word) and `bus_width_in` has no effect.
- R12: When the request is a fetch, `fetch_o` is high through every phase of the cycle, both halves of a split included, and low at all other times.
- R13: A request presented while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request from the core |
| req_addr | input | ADDR_W | Byte address (odd only for a high-byte-only request) |
| req_wdata | input | DATA_W | Write word |
| req_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an instruction fetch |
| cfg_adv_mode | input | 1 | 0 = latch pulse, 1 = latch valid level |
| cfg_wrh_mode | input | 1 | 0 = high-byte enable, 1 = high-byte write strobe |
| cfg_dyn_width | input | 1 | 1 = width from `bus_width_in` |
| cfg_wide | input | 1 | Static width when not dynamic (1 = word) |
| bus_width_in | input | 1 | Per-cycle width pin (1 = word) |
| ready_in | input | 1 | 0 extends the data phase |
| ad_in | input | DATA_W | Bus value seen by the controller |
| ad_out | output | DATA_W | Bus value driven by the controller |
| ad_oe | output | 1 | Bus drive enable |
| addr_strobe | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| hi_n | output | 1 | High-byte strobe, active low |
| fetch_o | output | 1 | Instruction-fetch indicator |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Completion pulse |
| rdata | output | DATA_W | Read word, valid with `done` |

## Verification
The properties assume that the two strobe-mode configuration bits change only while the controller is idle. They also assume that a request's byte enables match its address: 11 or 01 at an even address, 10 at an odd one. The directed tasks change configuration only between cycles and use only these enable/address pairs. They drive `bus_width_in` and `ready_in` steadily through each data phase, so the sampled width is fixed before the edge that ends the phase.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_END  = 2'd3
   } xbus_phase_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        ready_in,
   input  logic        wide_now,
   input  logic        both_bytes,
   output xbus_phase_e phase,
   output logic        capture,
   output logic        split_go,
   output logic        done
);
   logic last_q;

   // the data phase finishes on an edge where ready is high
   assign capture  = (phase == PH_DATA) && ready_in;
   assign split_go = capture && !wide_now && both_bytes;
   assign done     = (phase == PH_END) && last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         last_q <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) phase <= PH_ADDR;
            PH_ADDR: phase <= PH_DATA;
            PH_DATA: if (capture) begin
               phase  <= PH_END;
               last_q <= !split_go;
            end
            PH_END:  phase <= last_q ? PH_IDLE : PH_ADDR;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xbus_lanes.sv
module xbus_lanes
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_be,
   input  logic              req_write,
   input  logic              req_fetch,
   input  logic              split_go,
   input  logic              capture,
   input  logic              wide_now,
   input  xbus_phase_e       phase,
   input  logic [DATA_W-1:0] ad_in,
   output logic [1:0]        cur_be,
   output logic [1:0]        carry,
   output logic              cur_write,
   output logic              cur_fetch,
   output logic [DATA_W-1:0] ad_drive,
   output logic [DATA_W-1:0] rdata
);
   localparam int BYTE_W = DATA_W / 2;

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         wdata_q   <= '0;
         cur_be    <= '0;
         cur_write <= 1'b0;
         cur_fetch <= 1'b0;
      end else if (start) begin
         addr_q    <= req_addr;
         wdata_q   <= req_wdata;
         cur_be    <= req_be;
         cur_write <= req_write;
         cur_fetch <= req_fetch;
      end else if (split_go) begin
         addr_q[0] <= 1'b1;
         cur_be    <= 2'b10;
      end
   end

   // lanes the current cycle actually moves
   assign carry = wide_now ? cur_be : ((cur_be == 2'b11) ? 2'b01 : cur_be);

   always_comb begin
      if (phase == PH_ADDR)
         ad_drive = DATA_W'(addr_q);
      else if (cur_be == 2'b10)
         ad_drive = {wdata_q[DATA_W-1:BYTE_W], wdata_q[DATA_W-1:BYTE_W]};
      else
         ad_drive = wdata_q;
   end

   for (genvar l = 0; l < 2; l++) begin : g_lane
      logic [BYTE_W-1:0] byte_q;
      logic [BYTE_W-1:0] src;
      assign src = wide_now ? ad_in[l*BYTE_W +: BYTE_W] : ad_in[BYTE_W-1:0];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   byte_q <= '0;
         else if (start)               byte_q <= '0;
         else if (capture && carry[l]) byte_q <= src;
      end
   end

   assign rdata = {g_lane[1].byte_q, g_lane[0].byte_q};
endmodule

// File: rtl/xbus_strobes.sv
module xbus_strobes
   import xbus_pkg::*;
(
   input  xbus_phase_e phase,
   input  logic        cfg_adv_mode,
   input  logic        cfg_wrh_mode,
   input  logic [1:0]  cur_be,
   input  logic [1:0]  carry,
   input  logic        cur_write,
   input  logic        cur_fetch,
   output logic        addr_strobe,
   output logic        rd_n,
   output logic        wr_n,
   output logic        hi_n,
   output logic        fetch_o,
   output logic        ad_oe,
   output logic        busy
);
   logic in_addr, in_data, bhe_on, wrh_on;

   assign in_addr = (phase == PH_ADDR);
   assign in_data = (phase == PH_DATA);
   assign busy    = (phase != PH_IDLE);

   assign addr_strobe = cfg_adv_mode ? !(in_addr || in_data) : in_addr;
   assign rd_n    = !(in_data && !cur_write);
   assign wr_n    = !(in_data && cur_write);
   assign ad_oe   = in_addr || (in_data && cur_write);
   assign fetch_o = busy && cur_fetch;

   assign bhe_on = cur_write && ((in_addr && cur_be[1]) || (in_data && carry[1]));
   assign wrh_on = cur_write && in_data && carry[1];
   assign hi_n   = !(cfg_wrh_mode ? wrh_on : bhe_on);
endmodule

// File: rtl/xbus_cycle_ctl.sv
module xbus_cycle_ctl
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_be,
   input  logic              req_write,
   input  logic              req_fetch,
   input  logic              cfg_adv_mode,
   input  logic              cfg_wrh_mode,
   input  logic              cfg_dyn_width,
   input  logic              cfg_wide,
   input  logic              bus_width_in,
   input  logic              ready_in,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              addr_strobe,
   output logic              rd_n,
   output logic              wr_n,
   output logic              hi_n,
   output logic              fetch_o,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   if (DATA_W % 2 != 0 || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be an even width of at least 2");
   end
   if (ADDR_W > DATA_W || ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must fit on the shared bus");
   end

   xbus_phase_e phase;
   logic        start, capture, split_go, wide_now;
   logic        cur_write, cur_fetch;
   logic [1:0]  cur_be, carry;

   assign wide_now = cfg_dyn_width ? bus_width_in : cfg_wide;
   assign start    = req_valid && (phase == PH_IDLE);

   xbus_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .ready_in(ready_in),
      .wide_now(wide_now), .both_bytes(cur_be == 2'b11),
      .phase(phase), .capture(capture), .split_go(split_go), .done(done)
   );

   xbus_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_write(req_write), .req_fetch(req_fetch),
      .split_go(split_go), .capture(capture), .wide_now(wide_now),
      .phase(phase), .ad_in(ad_in),
      .cur_be(cur_be), .carry(carry), .cur_write(cur_write),
      .cur_fetch(cur_fetch), .ad_drive(ad_out), .rdata(rdata)
   );

   xbus_strobes u_strobes (
      .phase(phase), .cfg_adv_mode(cfg_adv_mode), .cfg_wrh_mode(cfg_wrh_mode),
      .cur_be(cur_be), .carry(carry), .cur_write(cur_write),
      .cur_fetch(cur_fetch), .addr_strobe(addr_strobe), .rd_n(rd_n),
      .wr_n(wr_n), .hi_n(hi_n), .fetch_o(fetch_o), .ad_oe(ad_oe), .busy(busy)
   );
endmodule

// File: rtl/xbus_cycle_ctl_chk.sv
module xbus_cycle_ctl_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_adv_mode,
   input logic cfg_wrh_mode,
   input logic ready_in,
   input logic addr_strobe,
   input logic rd_n,
   input logic wr_n,
   input logic hi_n,
   input logic ad_oe,
   input logic fetch_o,
   input logic busy,
   input logic done
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rd_n && wr_n && hi_n && !ad_oe && !fetch_o));

   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_ale_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_adv_mode && addr_strobe) |=> !addr_strobe);

   assert_ale_in_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_adv_mode && addr_strobe) |-> busy);

   assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !ready_in) |=> !rd_n);

   assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && !ready_in) |=> !wr_n);

   assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (!ad_oe && wr_n));

   assert_no_hi_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> hi_n);

   assert_wrh_with_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wrh_mode && !hi_n) |-> !wr_n);

   assert_fetch_in_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |-> busy);
endmodule

bind xbus_cycle_ctl xbus_cycle_ctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_adv_mode(cfg_adv_mode),
   .cfg_wrh_mode(cfg_wrh_mode), .ready_in(ready_in),
   .addr_strobe(addr_strobe), .rd_n(rd_n), .wr_n(wr_n), .hi_n(hi_n),
   .ad_oe(ad_oe), .fetch_o(fetch_o), .busy(busy), .done(done)
);

// File: tb/xbus_cycle_ctl_test.sv
module xbus_cycle_ctl_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_write = 1'b0;
   logic        req_fetch = 1'b0;
   logic        cfg_adv_mode = 1'b0;
   logic        cfg_wrh_mode = 1'b0;
   logic        cfg_dyn_width = 1'b0;
   logic        cfg_wide = 1'b1;
   logic        bus_width_in = 1'b1;
   logic        ready_in = 1'b1;
   logic [15:0] ad_in = '0;
   logic [15:0] ad_out, rdata;
   logic        ad_oe, addr_strobe, rd_n, wr_n, hi_n, fetch_o, busy, done;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xbus_cycle_ctl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write),
      .req_fetch(req_fetch), .cfg_adv_mode(cfg_adv_mode),
      .cfg_wrh_mode(cfg_wrh_mode), .cfg_dyn_width(cfg_dyn_width),
      .cfg_wide(cfg_wide), .bus_width_in(bus_width_in), .ready_in(ready_in),
      .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_strobe(addr_strobe),
      .rd_n(rd_n), .wr_n(wr_n), .hi_n(hi_n), .fetch_o(fetch_o), .busy(busy),
      .done(done), .rdata(rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // raise a request for one clock; returns at the address phase
   task automatic issue(input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be, input logic wr, input logic f);
      @(negedge clk);
      req_addr = a; req_wdata = d; req_be = be; req_write = wr; req_fetch = f;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 busy", busy, 0);
      chk("R1 rd_n", rd_n, 1);
      chk("R1 wr_n", wr_n, 1);
      chk("R1 hi_n", hi_n, 1);
      chk("R1 ad_oe", ad_oe, 0);
      chk("R1 fetch", fetch_o, 0);
      chk("R1 ale idle", addr_strobe, 0);
   endtask

   task automatic t_read_word_ale;
      cfg_adv_mode = 0; cfg_dyn_width = 0; cfg_wide = 1; ad_in = 16'hBEEF;
      issue(16'h1234, 16'h0, 2'b11, 1'b0, 1'b0);
      chk("R2 addr", ad_out, 16'h1234);
      chk("R2 oe addr", ad_oe, 1);
      chk("R3 ale high", addr_strobe, 1);
      chk("R6 rd_n in addr", rd_n, 1);
      @(negedge clk);
      req_addr = 16'h7776; req_valid = 1'b1; // R13 stray request
      chk("R3 ale low", addr_strobe, 0);
      chk("R6 rd_n data", rd_n, 0);
      chk("R6 released", ad_oe, 0);
      chk("R6 wr_n", wr_n, 1);
      chk("R8 no hi on read", hi_n, 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 done", done, 1);
      chk("R2 rdata", rdata, 16'hBEEF);
      chk("R6 rd_n end", rd_n, 1);
      @(negedge clk);
      chk("R2 done once", done, 0);
      chk("R13 stray ignored", busy, 0);
   endtask

   task automatic t_write_adv_wait;
      cfg_adv_mode = 1; cfg_wrh_mode = 0; cfg_wide = 1;
      @(negedge clk);
      chk("R4 adv idle high", addr_strobe, 1);
      issue(16'h2000, 16'hA55A, 2'b11, 1'b1, 1'b0);
      ready_in = 0;
      chk("R4 adv low addr", addr_strobe, 0);
      chk("R8 bhe addr", hi_n, 0);
      chk("R2 addr w", ad_out, 16'h2000);
      @(negedge clk);
      chk("R7 wr_n", wr_n, 0);
      chk("R7 data", ad_out, 16'hA55A);
      chk("R7 oe", ad_oe, 1);
      chk("R8 bhe data", hi_n, 0);
      chk("R4 adv low data", addr_strobe, 0);
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         chk("R5 wr held", wr_n, 0);
         chk("R5 no done", done, 0);
         chk("R5 bhe held", hi_n, 0);
      end
      ready_in = 1;
      @(negedge clk);
      chk("R4 adv high end", addr_strobe, 1);
      chk("R7 wr_n end", wr_n, 1);
      chk("R8 bhe end", hi_n, 1);
      chk("R2 done w", done, 1);
      @(negedge clk);
   endtask

   task automatic t_write_low_bhe;
      cfg_adv_mode = 0; cfg_wrh_mode = 0;
      issue(16'h3000, 16'h0077, 2'b01, 1'b1, 1'b0);
      chk("R8 low only addr", hi_n, 1);
      @(negedge clk);
      chk("R8 low only data", hi_n, 1);
      chk("R7 wr low byte", wr_n, 0);
      @(negedge clk); @(negedge clk);
   endtask

   task automatic t_write_wrh;
      cfg_wrh_mode = 1;
      issue(16'h3100, 16'h1357, 2'b11, 1'b1, 1'b0);
      chk("R9 wrh addr", hi_n, 1);
      @(negedge clk);
      chk("R9 wrh data", hi_n, 0);
      @(negedge clk);
      chk("R9 wrh end", hi_n, 1);
      @(negedge clk);
   endtask

   task automatic t_split_fetch_read;
      cfg_wrh_mode = 0; cfg_dyn_width = 1; bus_width_in = 0; cfg_wide = 1;
      issue(16'h4000, 16'h0, 2'b11, 1'b0, 1'b1);
      chk("R12 fetch addr", fetch_o, 1);
      chk("R10 even first", ad_out, 16'h4000);
      @(negedge clk);
      ad_in = 16'hEE11;
      chk("R12 fetch data", fetch_o, 1);
      @(negedge clk);
      chk("R10 no done mid", done, 0);
      chk("R12 fetch end1", fetch_o, 1);
      @(negedge clk);
      chk("R10 odd second", ad_out, 16'h4001);
      chk("R3 ale second", addr_strobe, 1);
      @(negedge clk);
      ad_in = 16'hDD22;
      chk("R10 rd second", rd_n, 0);
      @(negedge clk);
      chk("R10 done split", done, 1);
      chk("R10 assembled", rdata, 16'h2211);
      chk("R12 fetch end2", fetch_o, 1);
      @(negedge clk);
      chk("R12 fetch off", fetch_o, 0);
      chk("R10 idle", busy, 0);
   endtask

   task automatic t_static_narrow_write;
      cfg_dyn_width = 0; cfg_wide = 0; bus_width_in = 1; cfg_wrh_mode = 1;
      issue(16'h5000, 16'hC3B4, 2'b11, 1'b1, 1'b0);
      @(negedge clk);
      chk("R11 low byte", ad_out[7:0], 8'hB4);
      chk("R9 wrh first half", hi_n, 1);
      @(negedge clk);
      chk("R11 split ignores pin", done, 0);
      @(negedge clk);
      chk("R11 odd addr", ad_out, 16'h5001);
      @(negedge clk);
      chk("R7 high byte lanes", ad_out, 16'hC3C3);
      chk("R9 wrh second half", hi_n, 0);
      @(negedge clk);
      chk("R11 done", done, 1);
      @(negedge clk);
   endtask

   task automatic t_dyn_wide_read;
      cfg_dyn_width = 1; cfg_wide = 0; bus_width_in = 1; ad_in = 16'h9A8B;
      issue(16'h6000, 16'h0, 2'b11, 1'b0, 1'b0);
      chk("R12 no fetch", fetch_o, 0);
      @(negedge clk);
      @(negedge clk);
      chk("R10 wide one cycle", done, 1);
      chk("R10 wide data", rdata, 16'h9A8B);
      @(negedge clk);
      chk("R10 wide idle", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_read_word_ale;
      t_write_adv_wait;
      t_write_low_bhe;
      t_write_wrh;
      t_split_fetch_read;
      t_static_narrow_write;
      t_dyn_wide_read;
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule